// File: doc/BRIEF.md
# Trap Vector Address Generator

This block keeps the machine-level trap registers that decide where a trap handler starts. It holds the trap-vector register (a handler base address plus a two-bit dispatch mode), the trap cause register, the exception program counter, the trap value register and a scratch register. From the stored vector and cause it computes the handler entry address and flags whether that address is usable.

Software reaches the registers through a single-cycle CSR port. A write is stored on the next rising clock edge. Reads are combinational from the stored contents. The exception program counter is aligned on write, and the alignment follows a configuration input that says whether compressed (16-bit) instructions are enabled.

The trap-taking sequencer samples the target outputs when it redirects fetch. That sequencer and the privilege changes that go with it are outside this block.

Top module: `trapvec_gen`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads zero, `target_addr` is 0 and `target_valid` is 1.
- R2: A write to the vector register (address 0x305) whose bits 1:0 are 0 or 1 stores the whole word. Bits XLEN-1:2 form the handler base and bits 1:0 form the mode. Mode 0 is direct and mode 1 is vectored.
- R3: A write to the vector register whose bits 1:0 are 2 or 3 (reserved modes) takes the new base but keeps the previous mode.
- R4: In direct mode, `target_addr` equals the base with two zero bits appended, for any cause value.
- R5: In vectored mode, when the cause register's top bit is 1 (interrupt), `target_addr` is the base address plus the remaining cause bits shifted left by two, modulo 2^XLEN.
- R6: In vectored mode, when the cause register's top bit is 0 (exception), `target_addr` equals the base address.
- R7: `target_valid` is high only for a stored mode of 0 or 1. Because reserved modes are never stored, it stays high through any sequence of writes.
- R8: A write to the cause register (address 0x342) stores the value unmodified.
- R9: A write to the exception PC (address 0x341) clears bit 0 when `compressed_en` is 1, and clears bits 1:0 when it is 0. All other bits are kept.
- R10: The trap value register (0x343) and the scratch register (0x340) store any written value unmodified.
- R11: A write to an unmapped address changes no register, and a read of an unmapped address returns 0.
- R12: A write becomes visible on `csr_rdata` and on the target outputs in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Write strobe for the CSR port |
| csr_addr | input | 12 | CSR address, used for both read and write |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| compressed_en | input | 1 | Compressed instructions enabled; selects the exception PC alignment |
| target_addr | output | XLEN | Handler entry address |
| target_valid | output | 1 | Entry address is usable (stored mode is not reserved) |

## Verification
The hardest case to reach from the ports is a reserved mode arriving while vectored mode is active and an interrupt cause is loaded. Only then does a wrongly stored mode change the entry address instead of hiding behind direct mode. The stimulus first sets vectored mode and an interrupt cause, then writes bases carrying modes 2 and 3, and checks that the offset still applies to the new base. Carry-out of the address addition is reached by placing the base near the top of the address space and loading a large interrupt code. A long random phase then interleaves both alignment settings with writes to all mapped addresses and to an unmapped one.

// File: rtl/trapvec_pkg.sv
// Shared constants and types for the trap vector address generator.
// Assumes 12-bit CSR addresses and a two-bit vector mode field in bits 1:0.
package trapvec_pkg;
    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_EPC     = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;
    localparam logic [11:0] ADDR_TVAL    = 12'h343;
    localparam logic [11:0] ADDR_TVEC    = 12'h305;

    typedef enum logic [1:0] {
        VEC_DIRECT = 2'd0,
        VEC_TABLE  = 2'd1,
        VEC_RSV2   = 2'd2,
        VEC_RSV3   = 2'd3
    } vec_mode_e;

    function automatic logic mode_legal(input logic [1:0] m);
        return (m == VEC_DIRECT) || (m == VEC_TABLE);
    endfunction
endpackage

// File: rtl/trapvec_base_reg.sv
// Vector register: stores the handler base and the dispatch mode.
// Assumes writes carrying a reserved mode must leave the mode field as it was.
module trapvec_base_reg
    import trapvec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-3:0] base_q,
    output vec_mode_e       mode_q
);
    logic [1:0] new_mode;
    assign new_mode = wr_data[1:0];

    // Store the base on every write; store the mode only when it is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= VEC_DIRECT;
        end else if (wr_en) begin
            base_q <= wr_data[XLEN-1:2];
            if (mode_legal(new_mode)) mode_q <= vec_mode_e'(new_mode);
        end
    end

    // R3
    reserved_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_legal(wr_data[1:0])) |=> (mode_q == $past(mode_q)));

    // R2
    base_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base_q == $past(wr_data[XLEN-1:2])));
endmodule

// File: rtl/trapvec_pc_align.sv
// Exception PC register with alignment applied on write.
// Assumes the compressed-enable input is sampled in the same cycle as the write.
module trapvec_pc_align #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            compressed_en,
    output logic [XLEN-1:0] epc_q
);
    localparam logic [XLEN-1:0] MASK_HALF = {{(XLEN-1){1'b1}}, 1'b0};
    localparam logic [XLEN-1:0] MASK_WORD = {{(XLEN-2){1'b1}}, 2'b00};

    logic [XLEN-1:0] aligned;
    // Pick the alignment mask from the instruction-size configuration.
    always_comb aligned = wr_data & (compressed_en ? MASK_HALF : MASK_WORD);

    // Capture the aligned value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     epc_q <= '0;
        else if (wr_en) epc_q <= aligned;
    end

    // R9
    epc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && compressed_en) |=>
            (epc_q[0] == 1'b0 && epc_q[XLEN-1:1] == $past(wr_data[XLEN-1:1])));

    // R9
    epc_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !compressed_en) |=>
            (epc_q[1:0] == 2'b00 && epc_q[XLEN-1:2] == $past(wr_data[XLEN-1:2])));
endmodule

// File: rtl/trapvec_plain_reg.sv
// Unconstrained storage register (cause, trap value, scratch).
// Assumes every written value is legal and kept as written.
module trapvec_plain_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Hold the last written word.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

    // R8
    plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_data)));
endmodule

// File: rtl/trapvec_target_calc.sv
// Combinational handler entry address from the vector and cause registers.
// Assumes the cause register's top bit marks an interrupt.
module trapvec_target_calc
    import trapvec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-3:0] base,
    input  vec_mode_e       mode,
    input  logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] target_addr,
    output logic            target_valid
);
    logic [XLEN-1:0] base_addr;
    logic [XLEN-1:0] offset;
    logic            is_irq;

    assign base_addr = {base, 2'b00};
    assign offset    = {cause[XLEN-3:0], 2'b00};
    assign is_irq    = cause[XLEN-1];

    // Select the entry address by mode and cause kind.
    always_comb begin
        target_addr  = base_addr;
        target_valid = 1'b0;
        case (mode)
            VEC_DIRECT: target_valid = 1'b1;
            VEC_TABLE: begin
                target_valid = 1'b1;
                if (is_irq) target_addr = base_addr + offset;
            end
            default: target_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/trapvec_gen.sv
// Top of the trap vector address generator: CSR decode, register bank
// and target computation. Assumes a single-cycle write port and a
// combinational read of the addressed register.
module trapvec_gen
    import trapvec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            compressed_en,
    output logic [XLEN-1:0] target_addr,
    output logic            target_valid
);
    localparam int NPLAIN = 3;
    localparam logic [11:0] PLAIN_ADDR [NPLAIN] = '{ADDR_CAUSE, ADDR_TVAL, ADDR_SCRATCH};
    localparam int CAUSE_IDX = 0;

    logic [XLEN-3:0] base_q;
    vec_mode_e       mode_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] plain_q [NPLAIN];

    trapvec_base_reg #(.XLEN(XLEN)) u_base (
        .clk(clk), .rst_n(rst_n),
        .wr_en(csr_we && csr_addr == ADDR_TVEC),
        .wr_data(csr_wdata), .base_q(base_q), .mode_q(mode_q)
    );

    trapvec_pc_align #(.XLEN(XLEN)) u_epc (
        .clk(clk), .rst_n(rst_n),
        .wr_en(csr_we && csr_addr == ADDR_EPC),
        .wr_data(csr_wdata), .compressed_en(compressed_en), .epc_q(epc_q)
    );

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        trapvec_plain_reg #(.W(XLEN)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .wr_en(csr_we && csr_addr == PLAIN_ADDR[g]),
            .wr_data(csr_wdata), .q(plain_q[g])
        );
    end

    trapvec_target_calc #(.XLEN(XLEN)) u_calc (
        .base(base_q), .mode(mode_q), .cause(plain_q[CAUSE_IDX]),
        .target_addr(target_addr), .target_valid(target_valid)
    );

    // Read mux: addressed register, zero for unmapped addresses.
    always_comb begin
        csr_rdata = '0;
        if (csr_addr == ADDR_TVEC) csr_rdata = {base_q, mode_q};
        if (csr_addr == ADDR_EPC)  csr_rdata = epc_q;
        for (int i = 0; i < NPLAIN; i++)
            if (csr_addr == PLAIN_ADDR[i]) csr_rdata = plain_q[i];
    end

    // R7
    target_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_valid);

    // R4
    target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_addr[1:0] == 2'b00);
endmodule

// File: tb/trapvec_gen_test.sv
module trapvec_gen_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = 12'h000;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            compressed_en = 1'b0;
    logic [XLEN-1:0] target_addr;
    logic            target_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state.
    logic [31:0] m_tvec = '0, m_cause = '0, m_epc = '0, m_tval = '0, m_scr = '0;

    trapvec_gen #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .compressed_en(compressed_en),
        .target_addr(target_addr), .target_valid(target_valid)
    );

    always #10 clk = ~clk;

    // Model update on each rising edge from the inputs applied in the cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tvec = 0; m_cause = 0; m_epc = 0; m_tval = 0; m_scr = 0;
        end else if (csr_we) begin
            case (csr_addr)
                12'h305: begin
                    if (csr_wdata[1:0] < 2) m_tvec = csr_wdata;
                    else m_tvec = {csr_wdata[31:2], m_tvec[1:0]};
                end
                12'h342: m_cause = csr_wdata;
                12'h343: m_tval = csr_wdata;
                12'h340: m_scr = csr_wdata;
                12'h341: m_epc = compressed_en ? (csr_wdata / 2) * 2 : (csr_wdata / 4) * 4;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h305: return m_tvec;
            12'h342: return m_cause;
            12'h343: return m_tval;
            12'h340: return m_scr;
            12'h341: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_target();
        logic [31:0] b;
        b = {m_tvec[31:2], 2'b00};
        if (m_tvec[1:0] == 2'd1 && m_cause[31]) return b + m_cause * 4;
        return b;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare against the model in every cycle, well after the edge.
    always @(posedge clk) begin
        #15;
        if (!done) begin
            check("rdata", csr_rdata, exp_read(csr_addr));
            check("target", target_addr, exp_target());
            check("valid", {31'b0, target_valid}, 32'h1);
        end
    end

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic c, input string req);
        @(posedge clk);
        #2;
        csr_we = we; csr_addr = a; csr_wdata = d; compressed_en = c; cur_req = req;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [11:0] ADDRS [6] = '{12'h305, 12'h342, 12'h341, 12'h343, 12'h340, 12'h7FF};

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset contents
        step(0, 12'h305, 0, 0, "R1");
        step(0, 12'h342, 0, 0, "R1");
        step(0, 12'h341, 0, 0, "R1");
        // R2 / R12: vectored mode, visible next cycle
        step(1, 12'h305, 32'h1000_0001, 0, "R2");
        step(0, 12'h305, 0, 0, "R12");
        // R5: interrupt cause offsets the address
        step(1, 12'h342, 32'h8000_0007, 0, "R8");
        step(0, 12'h342, 0, 0, "R5");
        // R6: exception cause goes to base
        step(1, 12'h342, 32'h0000_0007, 0, "R8");
        step(0, 12'h342, 0, 0, "R6");
        step(1, 12'h342, 32'h8000_0003, 0, "R5");
        // R3: reserved modes keep vectored mode, take base
        step(1, 12'h305, 32'h2000_0003, 0, "R3");
        step(0, 12'h305, 0, 0, "R3");
        step(1, 12'h305, 32'h3000_0102, 0, "R3");
        step(0, 12'h305, 0, 0, "R7");
        // R4: direct mode ignores interrupt cause
        step(1, 12'h305, 32'h4000_0100, 0, "R4");
        step(0, 12'h305, 0, 0, "R4");
        // R3: reserved mode while direct stays direct
        step(1, 12'h305, 32'h5000_0003, 0, "R3");
        step(0, 12'h305, 0, 0, "R7");
        // R5: wrap-around of the addition
        step(1, 12'h305, 32'hFFFF_FFF1, 0, "R5");
        step(1, 12'h342, 32'hFFFF_FFF0, 0, "R5");
        step(0, 12'h342, 0, 0, "R5");
        // R9: exception PC alignment both ways
        step(1, 12'h341, 32'hABCD_EF03, 1, "R9");
        step(0, 12'h341, 0, 1, "R9");
        step(1, 12'h341, 32'hABCD_EF03, 0, "R9");
        step(0, 12'h341, 0, 0, "R9");
        // R10: trap value and scratch take anything
        step(1, 12'h343, 32'hFFFF_FFFF, 0, "R10");
        step(1, 12'h340, 32'hDEAD_BEEF, 0, "R10");
        step(0, 12'h343, 0, 0, "R10");
        step(0, 12'h340, 0, 0, "R10");
        // R11: unmapped write changes nothing, reads zero
        step(1, 12'h7FF, 32'h1234_5678, 0, "R11");
        step(0, 12'h7FF, 0, 0, "R11");
        step(0, 12'h340, 0, 0, "R11");
        step(0, 12'h305, 0, 0, "R11");
        // R12: random mix compared every cycle
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 1), ADDRS[$urandom_range(0, 5)], $urandom,
                 $urandom_range(0, 1), "R12");
        end
        step(0, 12'h305, 0, 0, "R12");
        @(posedge clk);
        #18;
        finish_run();
    end
endmodule